// File: doc/BRIEF.md
# SPI Slave Byte Port with Hardware-Cleared Ready Line

This block is a byte-wide SPI slave for a chip that runs other logic on its own system clock. It uses SPI mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge, and the most significant bit goes first. The local logic loads a response byte into a transmit buffer and reads received bytes from a separate holding register. A full flag marks a waiting received byte. Three sticky error flags report an overflow, a write collision and an aborted frame.

The slave drives a ready line back to the master. The local logic raises it when it loads the next response byte with the arm strobe set. The hardware lowers it as soon as the first SPI clock edge of the next byte arrives, so the line never depends on how fast the local logic reacts. A full-duplex exchange works as follows. The byte shifted out is the one sitting in the buffer when the byte begins. A response loaded after a byte completes therefore goes out during the following byte. Raising the select line resets the bit counter, so every frame starts aligned to a byte boundary.

The SPI pins are asynchronous. They pass through two-flop synchronisers. The system clock must run at least four times faster than the SPI clock.

Top module: `spirdy_slave`

## Requirements
- R1: After reset, `ready_o`, `rx_full_o`, `ovf_o`, `wcol_o`, `abort_o` and `miso_o` are all low.
- R2: While `cs_n_i` is low, the eight bits sampled on MOSI at the rising edges of SCLK, most significant first, appear on `rx_data_o` and set `rx_full_o`. During the same byte, MISO carries, most significant first, the transmit buffer contents as they stood at the first rising edge of that byte.
- R3: A byte written with `tx_wr_i` after a byte has completed is shifted out during the next byte.
- R4: A write with `tx_arm_i` high, made while no byte is in progress, raises `ready_o`. A write with `tx_arm_i` low leaves `ready_o` low.
- R5: `ready_o` falls within 4 system cycles of the first rising SCLK edge of a byte, with no action from the local side.
- R6: A pulse on `rx_rd_i` clears `rx_full_o`.
- R7: If a byte completes while `rx_full_o` is high, `ovf_o` sets and stays set. The new byte is dropped and `rx_data_o` keeps the older byte.
- R8: A `tx_wr_i` pulse during a byte (after its first rising edge and before its last) sets `wcol_o`, which stays set. The write is discarded: the buffer and `ready_o` do not change.
- R9: If `cs_n_i` rises while a byte is part-way shifted or while `ready_o` is high, `abort_o` sets and stays set and `ready_o` falls. The bit counter restarts, so the next frame is received aligned to a byte boundary.
- R10: A pulse on `flag_clr_i` clears `ovf_o`, `wcol_o` and `abort_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | SPI clock from the master (asynchronous) |
| mosi_i | input | 1 | Serial data from the master |
| cs_n_i | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master; held low while deselected |
| ready_o | output | 1 | Response byte ready; cleared by hardware on the next SPI clock |
| tx_wr_i | input | 1 | Strobe that writes `tx_data_i` into the transmit buffer |
| tx_arm_i | input | 1 | Raises ready together with an accepted write |
| tx_data_i | input | DATA_W | Response byte |
| rx_rd_i | input | 1 | Marks the received byte as read |
| rx_data_o | output | DATA_W | Received byte holding register |
| rx_full_o | output | 1 | A received byte is waiting |
| ovf_o | output | 1 | Sticky overflow flag |
| wcol_o | output | 1 | Sticky write-collision flag |
| abort_o | output | 1 | Sticky aborted-frame flag |
| flag_clr_i | input | 1 | Clears the three sticky flags |

## Verification
Each pin change needs two synchroniser stages and one edge-compare register before the block acts on it. A rising SCLK edge therefore takes effect, and ready falls, within 3 to 4 system cycles. A byte completes, and `rx_full_o` rises, within the same window after its eighth rising edge. Local strobes take effect one cycle later. The bench holds each SPI half period for 8 system cycles and samples MISO just before raising SCLK. It checks ready 4 cycles after the first rising edge and reads the flags at least half an SPI period after the last pin change, so every result is settled when it is sampled. Received bytes go into a queue of expected values. A monitor compares each one on the cycle `rx_full_o` rises.

// File: rtl/spirdy_pkg.sv
package spirdy_pkg;

    // Pin bundle after synchronisation
    typedef struct packed {
        logic sclk;
        logic mosi;
        logic cs_n;
    } spi_pins_t;

    // Events the shifter reports to the control logic
    typedef struct packed {
        logic sclk_rise;
        logic desel_rise;
        logic busy;
        logic done;
    } shift_evt_t;

    // Sticky error flags
    typedef struct packed {
        logic ovf;
        logic wcol;
        logic abort;
    } err_flags_t;

    localparam err_flags_t FLAGS_CLEAR = '{ovf: 1'b0, wcol: 1'b0, abort: 1'b0};

    function automatic int unsigned cnt_width(input int unsigned bits);
        return (bits < 2) ? 1 : $clog2(bits);
    endfunction

endpackage

// File: rtl/spirdy_sync.sv
module spirdy_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spirdy_shift.sv
module spirdy_shift
    import spirdy_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_pins_t         pins,
    input  logic [DATA_W-1:0] tx_byte,
    output shift_evt_t        evt,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso
);
    localparam int unsigned CNT_W = cnt_width(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic              sclk_q;
    logic              cs_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              rise;
    logic              fall;

    assign rise = pins.sclk & ~sclk_q & ~pins.cs_n;
    assign fall = ~pins.sclk & sclk_q & ~pins.cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            sclk_q <= pins.sclk;
            cs_q   <= pins.cs_n;
            if (pins.cs_n) begin
                bit_cnt <= '0;
                tx_sh   <= tx_byte;
            end else if (rise) begin
                rx_sh   <= {rx_sh[DATA_W-2:0], pins.mosi};
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
            end else if (bit_cnt == '0) begin
                tx_sh <= tx_byte;
            end else if (fall) begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign evt.sclk_rise  = rise;
    assign evt.desel_rise = pins.cs_n & ~cs_q;
    assign evt.busy       = (bit_cnt != '0);
    assign evt.done       = rise && (bit_cnt == LAST);
    assign rx_byte        = {rx_sh[DATA_W-2:0], pins.mosi};
    assign miso           = ~pins.cs_n & tx_sh[DATA_W-1];

    // R9
    desel_align_chk: assert property (@(posedge clk) disable iff (rst)
        evt.desel_rise |=> !evt.busy && !evt.done);

    // R2
    byte_end_chk: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !evt.busy);
endmodule

// File: rtl/spirdy_ctrl.sv
module spirdy_ctrl
    import spirdy_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_evt_t        evt,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_wr,
    input  logic              tx_arm,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] tx_buf,
    output logic [DATA_W-1:0] rx_hold,
    output logic              rx_full,
    output err_flags_t        flags,
    output logic              ready
);
    logic accept;
    logic take_rx;

    assign accept  = tx_wr & ~evt.busy;
    assign take_rx = evt.done & (~rx_full | rx_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf  <= '0;
            rx_hold <= '0;
            rx_full <= 1'b0;
            flags   <= FLAGS_CLEAR;
            ready   <= 1'b0;
        end else begin
            if (accept) begin
                tx_buf <= tx_data;
            end

            if (take_rx) begin
                rx_hold <= rx_byte;
                rx_full <= 1'b1;
            end else if (rx_rd) begin
                rx_full <= 1'b0;
            end

            if (flag_clr) begin
                flags <= FLAGS_CLEAR;
            end
            if (evt.done && rx_full && !rx_rd) begin
                flags.ovf <= 1'b1;
            end
            if (tx_wr && evt.busy) begin
                flags.wcol <= 1'b1;
            end
            if (evt.desel_rise && (evt.busy || ready)) begin
                flags.abort <= 1'b1;
            end

            if (evt.sclk_rise || evt.desel_rise) begin
                ready <= 1'b0;
            end else if (accept && tx_arm) begin
                ready <= 1'b1;
            end
        end
    end

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ovf) |-> $past(rx_full));

    // R6
    full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rx_rd && !evt.done |=> !rx_full);

    // R8
    wcol_discard_chk: assert property (@(posedge clk) disable iff (rst)
        tx_wr && evt.busy |=> $stable(tx_buf));
endmodule

// File: rtl/spirdy_slave.sv
module spirdy_slave
    import spirdy_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              cs_n_i,
    output logic              miso_o,
    output logic              ready_o,
    input  logic              tx_wr_i,
    input  logic              tx_arm_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              rx_rd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              ovf_o,
    output logic              wcol_o,
    output logic              abort_o,
    input  logic              flag_clr_i
);
    localparam int unsigned PIN_W = $bits(spi_pins_t);
    localparam spi_pins_t PIN_IDLE = '{sclk: 1'b0, mosi: 1'b0, cs_n: 1'b1};

    spi_pins_t         pins_raw;
    spi_pins_t         pins_s;
    shift_evt_t        evt;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] tx_buf;
    err_flags_t        flags;

    assign pins_raw = '{sclk: sclk_i, mosi: mosi_i, cs_n: cs_n_i};

    spirdy_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    spirdy_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .pins    (pins_s),
        .tx_byte (tx_buf),
        .evt     (evt),
        .rx_byte (rx_byte),
        .miso    (miso_o)
    );

    spirdy_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rx_byte  (rx_byte),
        .tx_wr    (tx_wr_i),
        .tx_arm   (tx_arm_i),
        .tx_data  (tx_data_i),
        .rx_rd    (rx_rd_i),
        .flag_clr (flag_clr_i),
        .tx_buf   (tx_buf),
        .rx_hold  (rx_data_o),
        .rx_full  (rx_full_o),
        .flags    (flags),
        .ready    (ready_o)
    );

    assign ovf_o   = flags.ovf;
    assign wcol_o  = flags.wcol;
    assign abort_o = flags.abort;

    // R5
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        evt.busy |-> !ready_o);

    // R1
    miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pins_s.cs_n |-> !miso_o);
endmodule

// File: tb/test_spirdy_slave.sv
module test_spirdy_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic       miso, ready;
    logic       tx_wr = 1'b0, tx_arm = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, ovf, wcol, abort_f;
    logic       flag_clr = 1'b0;

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         auto_rd = 1'b1;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    spirdy_slave i_spirdy_slave (
        .clk(clk), .rst(rst), .sclk_i(sclk), .mosi_i(mosi), .cs_n_i(cs_n),
        .miso_o(miso), .ready_o(ready), .tx_wr_i(tx_wr), .tx_arm_i(tx_arm),
        .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
        .rx_full_o(rx_full), .ovf_o(ovf), .wcol_o(wcol), .abort_o(abort_f),
        .flag_clr_i(flag_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] d, input bit arm);
        tx_data = d; tx_wr = 1'b1; tx_arm = arm;
        @(negedge clk);
        tx_wr = 1'b0; tx_arm = 1'b0;
    endtask

    task automatic pulse_read();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    // Driver: shifts one byte as master, queues the expected received byte
    task automatic spi_byte(input logic [7:0] mo, input logic [7:0] exp_mi, input int nbits,
                            input bit push, input bit midwr, input logic [7:0] wdat);
        logic [7:0] mi = 8'h00;
        if (push && nbits == 8) exp_q.push_back(mo);
        for (int b = 0; b < nbits; b++) begin
            mosi = mo[7-b];
            tick(HALF);
            mi = {mi[6:0], miso};
            sclk = 1'b1;
            if (b == 0) begin
                tick(4);
                check("R5 ready cleared by first clock", ready, 0);
                tick(HALF - 4);
            end else begin
                tick(HALF);
            end
            sclk = 1'b0;
            if (midwr && b == 3) load(wdat, 1'b1);
        end
        if (nbits == 8) check("R2/R3/R8 miso byte", mi, exp_mi);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: compares each newly received byte with the queue
    initial begin
        logic pf;
        pf = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (rx_full && !pf) begin
                    if (exp_q.size() == 0) check("R2 unexpected byte", rx_data, 32'hFFFF);
                    else check("R2 received byte", rx_data, exp_q.pop_front());
                    if (auto_rd) pulse_read();
                end
                pf = rx_full;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1
        check("R1 ready", ready, 0);
        check("R1 full", rx_full, 0);
        check("R1 flags", {ovf, wcol, abort_f}, 0);
        check("R1 miso", miso, 0);

        // R4
        load(8'hA5, 1'b0); tick(1);
        check("R4 no arm keeps ready low", ready, 0);
        load(8'hA5, 1'b1); tick(1);
        check("R4 arm raises ready", ready, 1);

        cs_n = 1'b0; tick(HALF);
        spi_byte(8'h3C, 8'hA5, 8, 1'b1, 1'b0, 8'h00); tick(HALF);
        // R3
        load(8'h5A, 1'b1); tick(1);
        check("R4 rearm", ready, 1);
        spi_byte(8'hC3, 8'h5A, 8, 1'b1, 1'b0, 8'h00); tick(HALF);

        // R8: write in mid-byte discarded
        load(8'h77, 1'b1);
        spi_byte(8'h0F, 8'h77, 8, 1'b1, 1'b1, 8'hEE); tick(HALF);
        check("R8 wcol set", wcol, 1);
        check("R8 ready unchanged", ready, 0);
        spi_byte(8'hF0, 8'h77, 8, 1'b1, 1'b0, 8'h00); tick(HALF);
        check("R8 wcol sticky", wcol, 1);

        // R7 overflow, R6 read clears
        auto_rd = 1'b0;
        spi_byte(8'h11, 8'h77, 8, 1'b1, 1'b0, 8'h00); tick(HALF);
        spi_byte(8'h22, 8'h77, 8, 1'b0, 1'b0, 8'h00); tick(HALF);
        check("R7 ovf set", ovf, 1);
        check("R7 older byte kept", rx_data, 8'h11);
        pulse_read(); tick(1);
        check("R6 full cleared", rx_full, 0);
        auto_rd = 1'b1;

        // R9 abort mid-byte
        spi_byte(8'hAA, 8'h00, 3, 1'b0, 1'b0, 8'h00);
        cs_n = 1'b1; tick(HALF);
        check("R9 abort mid-byte", abort_f, 1);
        // R10
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
        check("R10 flags cleared", {ovf, wcol, abort_f}, 0);
        load(8'h69, 1'b0);
        cs_n = 1'b0; tick(HALF);
        spi_byte(8'h96, 8'h69, 8, 1'b1, 1'b0, 8'h00); tick(HALF);
        check("R9 realigned frame", rx_data, 8'h96);
        cs_n = 1'b1; tick(HALF);
        check("R9 clean end no abort", abort_f, 0);

        // R9 select rises while ready armed
        cs_n = 1'b0; tick(HALF);
        load(8'h12, 1'b1); tick(1);
        check("R4 armed", ready, 1);
        cs_n = 1'b1; tick(HALF);
        check("R9 ready dropped", ready, 0);
        check("R9 abort while armed", abort_f, 1);

        tick(20);
        check("R2 queue drained", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule